// File: doc/BRIEF.md
# Alternating-Width One-Shot Pulse Timer

This block pairs a free-running down-counting carrier with a retriggerable one-shot pulse generator. Each time the carrier counter sits at zero, the next clock edge reloads it with the programmed period and starts a one-shot pulse. The pulse length comes from one of two width registers, and the choice flips on every carrier zero event, so consecutive pulses take their lengths from the first register, then the second, then the first again. When a pulse runs out, the block raises a one-cycle end strobe.

The same zero events also drive a carrier interrupt request, which can be thinned in two ways:

- **Count mode:** one request for every N zero events.
- **Phase mode:** a request only on those zero events whose width selection matches a chosen polarity.

Typical use is a modulated PWM engine. Software rewrites the two widths once per carrier period, and the interrupt is timed to one half of the alternating cycle.

Top module: `altPwmTimer`

## Requirements
- R1: While `rstN` is low, `pulseOut`, `pulseEnd`, `reloadSel` and `irqReq` are all 0.
- R2: The carrier counter starts at 0 after reset. A zero event happens on the first clock edge after reset release and then every `carrierPeriod`+1 cycles. At each zero event the counter is reloaded with the `carrierPeriod` value sampled at that edge.
- R3: At each zero event `pulseOut` goes high. The pulse width is taken from `widthA` when `reloadSel` is 0 and from `widthB` when `reloadSel` is 1, so the first pulse after reset uses `widthA`.
- R4: A pulse of width W stays high for exactly W cycles, with a width of 0 treated as 1. `pulseEnd` is high for the single cycle right after the pulse falls.
- R5: A zero event that arrives while a pulse is still running restarts it with the newly selected width. In that case no `pulseEnd` is produced.
- R6: `reloadSel` is 0 after reset and inverts on every zero event.
- R7: With `irqMode`=0, `irqReq` is a one-cycle pulse on every `irqCount`-th zero event, with an `irqCount` of 0 treated as 1. The pulse is high in the cycle following the zero-event edge.
- R8: Any change of the `irqCount` value clears the zero-event tally, so counting restarts from the edge at which the change is seen.
- R9: With `irqMode`=1, `irqReq` pulses on exactly those zero events whose `reloadSel` value before the edge equals `irqPolarity`.
- R10: With `irqMode`=1 and `irqPolarity`=0, a request comes on every other carrier period: the 1st, 3rd, 5th and so on after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| carrierPeriod | input | CNT_W | Carrier reload value (period is value+1 cycles) |
| widthA | input | CNT_W | Pulse width used when `reloadSel` is 0 |
| widthB | input | CNT_W | Pulse width used when `reloadSel` is 1 |
| irqMode | input | 1 | 0: count decimation, 1: phase gating |
| irqPolarity | input | 1 | Selection value that qualifies a request in phase mode |
| irqCount | input | DIV_W | Decimation factor N for count mode |
| pulseOut | output | 1 | One-shot pulse |
| pulseEnd | output | 1 | One-cycle strobe after a pulse completes |
| reloadSel | output | 1 | Width register picked for the next pulse |
| irqReq | output | 1 | Carrier interrupt request |

## Verification
Directed patterns isolate one behaviour each:
- Unequal short widths separate the width taken from the first register from the one taken from the second.
- Widths longer than the period show the difference between a restart and a normal end.
- A count of zero and a mid-run rewrite of N test the count-mode edge rules.
- Phase mode with both polarities tells a request tied to the selection apart from one tied to the tally.

Seeded random segments then vary the period (including 0), both widths, the mode, the polarity and N. Every output is compared each cycle against a bench model of the requirements.

// File: rtl/altPwmPkg.sv
package altPwmPkg;
  // Strobes from control to the one-shot datapath
  typedef struct packed {
    logic zeroEv;  // carrier counter is at zero this cycle
    logic useB;    // width register B is selected for this event
  } pwmStrobeT;
endpackage

// File: rtl/altPwmCtrl.sv
module altPwmCtrl
  import altPwmPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] carrierPeriod,
  input  logic             irqMode,
  input  logic             irqPolarity,
  input  logic [DIV_W-1:0] irqCount,
  output pwmStrobeT        strobe,
  output logic             reloadSel,
  output logic             irqReq
);
  localparam int DW1 = DIV_W + 1;

  logic [CNT_W-1:0] carCnt;
  logic [DIV_W-1:0] divCnt, nPrev, divBase, nEff;
  logic [DW1-1:0]   divNext;
  logic             selQ, irqQ, zeroEv, divHit;

  assign zeroEv  = (carCnt == '0);
  assign nEff    = (irqCount == '0) ? DIV_W'(1) : irqCount;
  assign divBase = (irqCount != nPrev) ? '0 : divCnt;
  assign divNext = {1'b0, divBase} + DW1'(1);
  assign divHit  = (divNext >= {1'b0, nEff});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carCnt <= '0;
      selQ   <= 1'b0;
      divCnt <= '0;
      nPrev  <= '0;
      irqQ   <= 1'b0;
    end else begin
      nPrev  <= irqCount;
      irqQ   <= 1'b0;
      divCnt <= divBase;
      if (zeroEv) begin
        carCnt <= carrierPeriod;
        selQ   <= ~selQ;
        if (irqMode) begin
          irqQ <= (selQ == irqPolarity);
        end else begin
          irqQ   <= divHit;
          divCnt <= divHit ? '0 : divNext[DIV_W-1:0];
        end
      end else begin
        carCnt <= carCnt - CNT_W'(1);
      end
    end
  end

  assign strobe.zeroEv = zeroEv;
  assign strobe.useB   = selQ;
  assign reloadSel     = selQ;
  assign irqReq        = irqQ;

  AST_CAR_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    zeroEv |=> carCnt == $past(carrierPeriod)); // R2
  AST_SEL_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    zeroEv |=> reloadSel != $past(reloadSel)); // R6
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !zeroEv |=> $stable(reloadSel)); // R6
  AST_IRQ_ON_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> $past(zeroEv)); // R7
  AST_PHASE_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (irqMode && zeroEv) |=> irqReq == ($past(reloadSel) == $past(irqPolarity))); // R9
endmodule

// File: rtl/altPwmShot.sv
module altPwmShot
  import altPwmPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] widthA,
  input  logic [CNT_W-1:0] widthB,
  input  pwmStrobeT        strobe,
  output logic             pulseOut,
  output logic             pulseEnd
);
  logic [CNT_W-1:0] shotCnt, wPick, wLoad;
  logic             active, endQ;

  assign wPick = strobe.useB ? widthB : widthA;
  assign wLoad = (wPick == '0) ? CNT_W'(1) : wPick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shotCnt <= '0;
      active  <= 1'b0;
      endQ    <= 1'b0;
    end else if (strobe.zeroEv) begin
      shotCnt <= wLoad;
      active  <= 1'b1;
      endQ    <= 1'b0;
    end else if (active && shotCnt == CNT_W'(1)) begin
      shotCnt <= '0;
      active  <= 1'b0;
      endQ    <= 1'b1;
    end else begin
      endQ <= 1'b0;
      if (active) shotCnt <= shotCnt - CNT_W'(1);
    end
  end

  assign pulseOut = active;
  assign pulseEnd = endQ;

  AST_START: assert property (@(posedge clk) disable iff (!rstN)
    strobe.zeroEv |=> pulseOut); // R3
  AST_END_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    pulseEnd |-> (!pulseOut && $past(pulseOut))); // R4
  AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    pulseEnd |=> !pulseEnd); // R4
  AST_NO_END_ON_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strobe.zeroEv |=> !pulseEnd); // R5
endmodule

// File: rtl/altPwmTimer.sv
module altPwmTimer
  import altPwmPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] carrierPeriod,
  input  logic [CNT_W-1:0] widthA,
  input  logic [CNT_W-1:0] widthB,
  input  logic             irqMode,
  input  logic             irqPolarity,
  input  logic [DIV_W-1:0] irqCount,
  output logic             pulseOut,
  output logic             pulseEnd,
  output logic             reloadSel,
  output logic             irqReq
);
  pwmStrobeT strobe;

  altPwmCtrl #(.CNT_W(CNT_W), .DIV_W(DIV_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .carrierPeriod(carrierPeriod),
    .irqMode(irqMode), .irqPolarity(irqPolarity), .irqCount(irqCount),
    .strobe(strobe), .reloadSel(reloadSel), .irqReq(irqReq)
  );

  altPwmShot #(.CNT_W(CNT_W)) i_shot (
    .clk(clk), .rstN(rstN), .widthA(widthA), .widthB(widthB),
    .strobe(strobe), .pulseOut(pulseOut), .pulseEnd(pulseEnd)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |-> !(pulseOut || pulseEnd || reloadSel || irqReq)); // R1
endmodule

// File: tb/test_altPwmTimer.sv
`timescale 1ns/1ps
module test_altPwmTimer;
  localparam int CNT_W = 16;
  localparam int DIV_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CNT_W-1:0] carrierPeriod = '0, widthA = '0, widthB = '0;
  logic irqMode = 1'b0, irqPolarity = 1'b0;
  logic [DIV_W-1:0] irqCount = '0;
  logic pulseOut, pulseEnd, reloadSel, irqReq;

  int checks = 0, failures = 0;
  bit checkEn = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  altPwmTimer #(.CNT_W(CNT_W), .DIV_W(DIV_W)) i_altPwmTimer (
    .clk(clk), .rstN(rstN), .carrierPeriod(carrierPeriod),
    .widthA(widthA), .widthB(widthB), .irqMode(irqMode),
    .irqPolarity(irqPolarity), .irqCount(irqCount),
    .pulseOut(pulseOut), .pulseEnd(pulseEnd),
    .reloadSel(reloadSel), .irqReq(irqReq)
  );

  // Requirement model state
  int  mCar, mDiv, mNPrev, mOne;
  bit  mSel, mAct, mEnd, mIrq, mModeUsed;

  function automatic int effN(int n);
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int effW(int w);
    return (w == 0) ? 1 : w;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCar = 0; mSel = 0; mDiv = 0; mNPrev = 0; mOne = 0;
      mAct = 0; mEnd = 0; mIrq = 0; mModeUsed = 0;
    end else begin
      bit zero;
      int base;
      zero = (mCar == 0);
      base = (int'(irqCount) != mNPrev) ? 0 : mDiv;    // R8
      mNPrev = int'(irqCount);
      mDiv = base;
      mIrq = 0;
      mEnd = 0;
      if (zero) begin
        mModeUsed = irqMode;
        if (irqMode) mIrq = (mSel == irqPolarity);      // R9
        else begin                                      // R7
          mIrq = (base + 1 >= effN(int'(irqCount)));
          mDiv = mIrq ? 0 : base + 1;
        end
        mOne = effW(mSel ? int'(widthB) : int'(widthA)); // R3
        mAct = 1;
        mSel = ~mSel;
        mCar = int'(carrierPeriod);
      end else begin
        if (mAct) begin
          if (mOne == 1) begin mAct = 0; mOne = 0; mEnd = 1; end
          else mOne = mOne - 1;
        end
        mCar = mCar - 1;
      end
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checkEn && rstN && !finished) begin
      check(pulseOut == mAct, "R3 pulseOut", pulseOut, mAct);
      check(pulseEnd == mEnd, "R4 pulseEnd", pulseEnd, mEnd);
      check(reloadSel == mSel, "R6 reloadSel", reloadSel, mSel);
      check(irqReq == mIrq, mModeUsed ? "R9 irqReq" : "R7 irqReq", irqReq, mIrq);
    end
  end

  task automatic doReset();
    @(negedge clk); #1;
    rstN = 1'b0;
    @(negedge clk);
    check({pulseOut, pulseEnd, reloadSel, irqReq} == 4'b0, "R1 reset state",
          {pulseOut, pulseEnd, reloadSel, irqReq}, 0);
    #1 rstN = 1'b1;
    checkEn = 1'b1;
  endtask

  // Run n cycles counting observed events at negedges
  int nIrq, nEnd, nHigh, nTog;
  task automatic run(int n);
    bit prevSel;
    nIrq = 0; nEnd = 0; nHigh = 0; nTog = 0;
    prevSel = reloadSel;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      nIrq += irqReq; nEnd += pulseEnd; nHigh += pulseOut;
      if (reloadSel != prevSel) nTog++;
      prevSel = reloadSel;
    end
    #1;
  endtask

  task automatic setup(int p, int a, int b, bit md, bit pol, int n);
    carrierPeriod = CNT_W'(p); widthA = CNT_W'(a); widthB = CNT_W'(b);
    irqMode = md; irqPolarity = pol; irqCount = DIV_W'(n);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);

    // R1, R3, R4: unequal widths, first pulse from widthA
    setup(9, 2, 4, 0, 0, 1);
    doReset();
    run(20);
    check(nHigh == 6, "R3 width sum A then B", nHigh, 6);
    check(nEnd == 2, "R4 end strobes", nEnd, 2);

    // R2, R10: phase mode polarity 0, every other period
    setup(5, 3, 2, 1, 0, 1);
    doReset();
    run(72);
    check(nTog == 12, "R2 zero events in 72 cycles", nTog, 12);
    check(nIrq == 6, "R10 every other period", nIrq, 6);

    // R9: polarity 1 selects the other half
    setup(5, 3, 2, 1, 1, 1);
    doReset();
    run(1);
    check(nIrq == 0, "R9 no request on first event pol1", nIrq, 0);
    run(6);
    check(nIrq == 1, "R9 request on second event pol1", nIrq, 1);

    // R7: count mode N=3
    setup(3, 1, 1, 0, 0, 3);
    doReset();
    run(48);
    check(nIrq == 4, "R7 every third event", nIrq, 4);

    // R7: N=0 treated as 1
    setup(3, 1, 1, 0, 0, 0);
    doReset();
    run(20);
    check(nIrq == 5, "R7 N zero as one", nIrq, 5);

    // R5: widths longer than period restart without end strobe
    setup(3, 8, 8, 0, 0, 1);
    doReset();
    run(40);
    check(nEnd == 0, "R5 no end on restart", nEnd, 0);
    check(nHigh == 40, "R5 pulse held by restarts", nHigh, 40);

    // R8: rewrite of N clears the tally
    setup(1, 1, 1, 0, 0, 4);
    doReset();
    run(6);
    check(nIrq == 0, "R8 tally before rewrite", nIrq, 0);
    irqCount = DIV_W'(2);
    run(2);
    check(nIrq == 0, "R8 no request right after rewrite", nIrq, 0);
    run(2);
    check(nIrq == 1, "R8 request after fresh count", nIrq, 1);

    // Random segments checked against the model every cycle
    for (int s = 0; s < 40; s++) begin
      setup($urandom_range(0, 12), $urandom_range(0, 15), $urandom_range(0, 15),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom_range(0, 5));
      if ($urandom_range(0, 4) == 0) doReset();
      run(30);
      if ($urandom_range(0, 2) == 0) irqCount = DIV_W'($urandom_range(0, 5)); // R8
      run(30);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cyc;
    for (cyc = 0; cyc < 150000; cyc++) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule